// File: doc/BRIEF.md
# Parallel Flash Identification Probe

This engine talks to a byte-wide parallel flash over a simple single-cycle bus and discovers which part is attached. After a start pulse it issues the three-write command that switches the flash into identification mode. It reads the manufacturer byte at offset 0 and the device byte at offset 1. A byte equal to 0x7F is a continuation marker: the engine then fetches one more byte, from offset 0x100 for the manufacturer or 0x101 for the device, and forms a 16-bit identifier.

It then issues the three-write leave command and waits a settle time. It reads the same offsets again, with the same continuation rule, to learn what the ordinary array holds there. It reports both identifiers, whether they equal the expected pair, whether the final manufacturer byte fails odd parity, and whether either identifier is indistinguishable from plain array content. A false identification looks exactly like that last case.

The short wait after each of the first two command writes is fixed. The settle wait after the third write of each sequence comes from a timing selector. The selector can take a caller-given time in microseconds, take no wait at all, or fall back to long built-in defaults. Its fourth setting aborts the probe before any bus access. All waits are counted in clock cycles through a cycles-per-microsecond parameter.

Top module: `flash_id_probe`

## Requirements
- R1: The entry sequence writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0x90 to 0x5555, in that order and as the first bus operations after start.
- R2: After each of the first two writes of either command sequence, the next bus operation starts exactly GAP_US*CYC_PER_US+2 cycles after the write cycle.
- R3: After the third write of a sequence, the next operation starts D+2 cycles later. timing_mode is latched at start and sets D as follows: 2'b00 gives timing_us*CYC_PER_US; 2'b01 gives 0; 2'b10 gives DEF_ENTRY_US*CYC_PER_US after entry and DEF_EXIT_US*CYC_PER_US after exit.
- R4: With timing_mode 2'b11 at start, done and aborted are high in the following cycle, no bus operation occurs, and the identifiers and all flags read zero.
- R5: In identification mode, offset 0 is read and then offset 1. bus_rdata is taken in the cycle after bus_re.
- R6: A read byte of 0x7F yields {0x7F, byte at 0x100} for the manufacturer or {0x7F, byte at 0x101} for the device. Any other byte b yields {0x00, b}. Only one extra level is followed.
- R7: The leave sequence writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xF0 to 0x5555, after all identification reads.
- R8: After leaving, offsets 0 and 1 are re-read with the R6 rule. mfr_alias and dev_alias are high when the identifier equals the value re-read for it.
- R9: parity_err is high when the low byte of mfr_id has an even number of ones.
- R10: id_match is high only when mfr_id equals exp_mfr and dev_id equals exp_dev.
- R11: done is a one-cycle pulse at which all outputs are valid. busy stays high from start until done. A start pulse while busy has no effect.
- R12: bus_we and bus_re are never high together, neither is high while idle, and every write is followed by at least one cycle without a bus operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a probe when idle |
| timing_mode | input | 2 | 00 given time, 01 none, 10 defaults, 11 abort |
| timing_us | input | US_W | Settle time in microseconds for mode 00 |
| exp_mfr | input | 16 | Expected manufacturer identifier |
| exp_dev | input | 16 | Expected device identifier |
| bus_addr | output | AW | Flash byte address |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | Write strobe, one cycle |
| bus_re | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_re |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Last probe refused its timing setting |
| mfr_id | output | 16 | Extended manufacturer identifier |
| dev_id | output | 16 | Extended device identifier |
| id_match | output | 1 | Both identifiers equal the expected pair |
| parity_err | output | 1 | Manufacturer low byte has even parity |
| mfr_alias | output | 1 | Manufacturer identifier equals array content |
| dev_alias | output | 1 | Device identifier equals array content |

## Verification
The properties assume three things about the inputs. exp_mfr and exp_dev hold steady from start until the cycle after done. bus_rdata answers each read in the following cycle. timing_mode is only sampled on an accepted start. The bench meets these by changing the expected values only while the engine is idle. Its flash model registers read data on the edge that sees bus_re. A second start is sent in the middle of a probe, with the abort setting on the selector, to show that nothing follows from it.

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int AW           = 16,
  parameter int US_W         = 16,
  parameter int CYC_PER_US   = 2,
  parameter int GAP_US       = 10,
  parameter int DEF_ENTRY_US = 10000,
  parameter int DEF_EXIT_US  = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      timing_mode,
  input  logic [US_W-1:0] timing_us,
  input  logic [15:0]     exp_mfr,
  input  logic [15:0]     exp_dev,
  output logic [AW-1:0]   bus_addr,
  output logic [7:0]      bus_wdata,
  output logic            bus_we,
  output logic            bus_re,
  input  logic [7:0]      bus_rdata,
  output logic            busy,
  output logic            done,
  output logic            aborted,
  output logic [15:0]     mfr_id,
  output logic [15:0]     dev_id,
  output logic            id_match,
  output logic            parity_err,
  output logic            mfr_alias,
  output logic            dev_alias
);

  localparam int CW = 32;
  localparam logic [CW-1:0] GAP_CYC = CW'(GAP_US * CYC_PER_US);
  localparam logic [CW-1:0] DEF_ENT = CW'(DEF_ENTRY_US * CYC_PER_US);
  localparam logic [CW-1:0] DEF_EXT = CW'(DEF_EXIT_US * CYC_PER_US);
  localparam logic [7:0]    CONT    = 8'h7F;
  localparam logic [AW-1:0] A_CMD1  = AW'(16'h5555);
  localparam logic [AW-1:0] A_CMD2  = AW'(16'h2AAA);

  typedef enum logic [4:0] {
    S_IDLE, S_EN1, S_EN2, S_EN3, S_RM, S_RD, S_RMX, S_RDX,
    S_EX1, S_EX2, S_EX3, S_CM, S_CD, S_CMX, S_CDX, S_FIN
  } state_t;

  state_t        st, nxt;
  logic          ph;
  logic [CW-1:0] cnt, ent_cyc, ext_cyc, hold_c;
  logic [15:0]   id_m, id_d, ar_m, ar_d;
  logic          is_wr, is_rd, skip;
  logic [CW-1:0] user_cyc;

  assign user_cyc = CW'(timing_us) * CW'(CYC_PER_US);
  assign nxt      = (st == S_FIN) ? S_IDLE : state_t'(st + 5'd1);
  assign busy     = (st != S_IDLE);
  assign mfr_id   = id_m;
  assign dev_id   = id_d;
  assign bus_we   = is_wr && !ph;
  assign bus_re   = is_rd && !ph && !skip;

  always_comb begin
    is_wr     = 1'b0;
    is_rd     = 1'b0;
    skip      = 1'b0;
    bus_addr  = '0;
    bus_wdata = 8'h00;
    hold_c    = GAP_CYC;
    case (st)
      S_EN1, S_EX1: begin is_wr = 1'b1; bus_addr = A_CMD1; bus_wdata = 8'hAA; end
      S_EN2, S_EX2: begin is_wr = 1'b1; bus_addr = A_CMD2; bus_wdata = 8'h55; end
      S_EN3: begin is_wr = 1'b1; bus_addr = A_CMD1; bus_wdata = 8'h90; hold_c = ent_cyc; end
      S_EX3: begin is_wr = 1'b1; bus_addr = A_CMD1; bus_wdata = 8'hF0; hold_c = ext_cyc; end
      S_RM, S_CM: begin is_rd = 1'b1; bus_addr = AW'(16'h0000); end
      S_RD, S_CD: begin is_rd = 1'b1; bus_addr = AW'(16'h0001); end
      S_RMX: begin is_rd = 1'b1; bus_addr = AW'(16'h0100); skip = (id_m[7:0] != CONT); end
      S_RDX: begin is_rd = 1'b1; bus_addr = AW'(16'h0101); skip = (id_d[7:0] != CONT); end
      S_CMX: begin is_rd = 1'b1; bus_addr = AW'(16'h0100); skip = (ar_m[7:0] != CONT); end
      S_CDX: begin is_rd = 1'b1; bus_addr = AW'(16'h0101); skip = (ar_d[7:0] != CONT); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; cnt <= '0;
      ent_cyc <= '0; ext_cyc <= '0;
      id_m <= '0; id_d <= '0; ar_m <= '0; ar_d <= '0;
      done <= 1'b0; aborted <= 1'b0; id_match <= 1'b0;
      parity_err <= 1'b0; mfr_alias <= 1'b0; dev_alias <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          id_match <= 1'b0; parity_err <= 1'b0;
          mfr_alias <= 1'b0; dev_alias <= 1'b0;
          id_m <= '0; id_d <= '0;
          ph <= 1'b0;
          if (timing_mode == 2'b11) begin
            aborted <= 1'b1;
            done    <= 1'b1;
          end else begin
            aborted <= 1'b0;
            st      <= S_EN1;
            case (timing_mode)
              2'b00:   begin ent_cyc <= user_cyc; ext_cyc <= user_cyc; end
              2'b01:   begin ent_cyc <= '0;       ext_cyc <= '0;       end
              default: begin ent_cyc <= DEF_ENT;  ext_cyc <= DEF_EXT;  end
            endcase
          end
        end
        S_FIN: begin
          id_match   <= (id_m == exp_mfr) && (id_d == exp_dev);
          parity_err <= ~^id_m[7:0];
          mfr_alias  <= (id_m == ar_m);
          dev_alias  <= (id_d == ar_d);
          done       <= 1'b1;
          st         <= S_IDLE;
        end
        default: begin
          if (is_wr) begin
            if (!ph) begin
              ph  <= 1'b1;
              cnt <= hold_c;
            end else if (cnt == '0) begin
              ph <= 1'b0;
              st <= nxt;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end else if (is_rd) begin
            if (!ph) begin
              if (skip) st <= nxt;
              else      ph <= 1'b1;
            end else begin
              case (st)
                S_RM:  id_m <= {8'h00, bus_rdata};
                S_RD:  id_d <= {8'h00, bus_rdata};
                S_RMX: id_m <= {id_m[7:0], bus_rdata};
                S_RDX: id_d <= {id_d[7:0], bus_rdata};
                S_CM:  ar_m <= {8'h00, bus_rdata};
                S_CD:  ar_d <= {8'h00, bus_rdata};
                S_CMX: ar_m <= {ar_m[7:0], bus_rdata};
                S_CDX: ar_d <= {ar_d[7:0], bus_rdata};
                default: ;
              endcase
              ph <= 1'b0;
              st <= nxt;
            end
          end
        end
      endcase
    end
  end

endmodule

module flash_id_probe_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    timing_mode,
  input logic [15:0]   exp_mfr,
  input logic [15:0]   exp_dev,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic          busy,
  input logic          done,
  input logic          aborted,
  input logic [15:0]   mfr_id,
  input logic [15:0]   dev_id,
  input logic          id_match,
  input logic          parity_err
);

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_we && !bus_re);

  assert_write_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we && !bus_re);

  assert_cmd_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_wdata == 8'hAA || bus_wdata == 8'h55 ||
                bus_wdata == 8'h90 || bus_wdata == 8'hF0));

  assert_read_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |-> (bus_addr == AW'(16'h0000) || bus_addr == AW'(16'h0001) ||
                bus_addr == AW'(16'h0100) || bus_addr == AW'(16'h0101)));

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && timing_mode == 2'b11) |=> done && aborted && !busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_until_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

  assert_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !aborted) |-> parity_err == (($countones(mfr_id[7:0]) % 2) == 0));

  assert_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !aborted) |-> id_match == (mfr_id == exp_mfr && dev_id == exp_dev));

endmodule

bind flash_id_probe flash_id_probe_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .timing_mode(timing_mode),
  .exp_mfr(exp_mfr), .exp_dev(exp_dev), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .busy(busy),
  .done(done), .aborted(aborted), .mfr_id(mfr_id), .dev_id(dev_id),
  .id_match(id_match), .parity_err(parity_err)
);

// File: tb/tb_flash_id_probe.sv
`timescale 1ns/1ps
module tb_flash_id_probe;
  localparam int AW = 16, US_W = 16, CPU = 2, GAP = 10, DEF_E = 10000, DEF_X = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] timing_mode = 2'b00;
  logic [US_W-1:0] timing_us = '0;
  logic [15:0] exp_mfr = '0, exp_dev = '0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic bus_we, bus_re, busy, done, aborted, id_match, parity_err, mfr_alias, dev_alias;
  logic [15:0] mfr_id, dev_id;

  always #2.5 clk = ~clk;

  flash_id_probe #(.AW(AW), .US_W(US_W), .CYC_PER_US(CPU), .GAP_US(GAP),
                   .DEF_ENTRY_US(DEF_E), .DEF_EXIT_US(DEF_X)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .timing_mode(timing_mode),
    .timing_us(timing_us), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .aborted(aborted),
    .mfr_id(mfr_id), .dev_id(dev_id), .id_match(id_match), .parity_err(parity_err),
    .mfr_alias(mfr_alias), .dev_alias(dev_alias));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model: identification table and array table
  logic [7:0] id0, id1, id100, id101, ar0, ar1, ar100, ar101;
  logic idm = 1'b0;
  always @(posedge clk) begin
    if (bus_we) begin
      if (bus_wdata == 8'h90) idm <= 1'b1;
      else if (bus_wdata == 8'hF0) idm <= 1'b0;
    end
    if (bus_re) begin
      case (bus_addr)
        16'h0000: bus_rdata <= idm ? id0   : ar0;
        16'h0001: bus_rdata <= idm ? id1   : ar1;
        16'h0100: bus_rdata <= idm ? id100 : ar100;
        16'h0101: bus_rdata <= idm ? id101 : ar101;
        default:  bus_rdata <= 8'h00;
      endcase
    end
  end

  // expected bus operations: kind 1 write, 2 read; gap -1 is unchecked
  int q_kind[$], q_addr[$], q_data[$], q_gap[$];
  string q_tag[$];
  int cyc = 0, last_op = 0;

  task automatic push(input int k, input int a, input int d, input int g, input string t);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
    q_gap.push_back(g); q_tag.push_back(t);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && (bus_we || bus_re)) begin
      if (q_kind.size() == 0) begin
        chk(0, "R4/R12 unexpected bus operation", int'(bus_addr), -1);
      end else begin
        int k, a, d, g;
        string t;
        k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
        g = q_gap.pop_front(); t = q_tag.pop_front();
        chk(k == (bus_we ? 1 : 2), {t, " kind"}, bus_we ? 1 : 2, k);
        chk(int'(bus_addr) == a, {t, " addr"}, int'(bus_addr), a);
        if (k == 1) chk(int'(bus_wdata) == d, {t, " data"}, int'(bus_wdata), d);
        if (g >= 0) chk(cyc - last_op == g, {t, " gap"}, cyc - last_op, g);
      end
      last_op = cyc;
    end
  end

  function automatic logic [15:0] ext(input logic [7:0] a, input logic [7:0] b);
    return (a == 8'h7F) ? {8'h7F, b} : {8'h00, a};
  endfunction

  task automatic probe(input logic [1:0] mode, input int us, input bit restart);
    int de, dx, g, wd;
    logic [15:0] em, ed, am, ad;
    g  = GAP * CPU;
    de = (mode == 2'b00) ? us * CPU : (mode == 2'b01) ? 0 : DEF_E * CPU;
    dx = (mode == 2'b00) ? us * CPU : (mode == 2'b01) ? 0 : DEF_X * CPU;
    em = ext(id0, id100); ed = ext(id1, id101);
    am = ext(ar0, ar100); ad = ext(ar1, ar101);
    if (mode != 2'b11) begin
      push(1, 16'h5555, 8'hAA, -1, "R1 entry#1");
      push(1, 16'h2AAA, 8'h55, g + 2, "R1/R2 entry#2");
      push(1, 16'h5555, 8'h90, g + 2, "R1/R2 entry#3");
      push(2, 16'h0000, 0, de + 2, "R3/R5 id read 0");
      push(2, 16'h0001, 0, 2, "R5 id read 1");
      if (id0 == 8'h7F) push(2, 16'h0100, 0, -1, "R6 mfr continuation");
      if (id1 == 8'h7F) push(2, 16'h0101, 0, -1, "R6 dev continuation");
      push(1, 16'h5555, 8'hAA, -1, "R7 exit#1");
      push(1, 16'h2AAA, 8'h55, g + 2, "R7/R2 exit#2");
      push(1, 16'h5555, 8'hF0, g + 2, "R7/R2 exit#3");
      push(2, 16'h0000, 0, dx + 2, "R3/R8 array read 0");
      push(2, 16'h0001, 0, 2, "R8 array read 1");
      if (ar0 == 8'h7F) push(2, 16'h0100, 0, -1, "R8 array continuation 0x100");
      if (ar1 == 8'h7F) push(2, 16'h0101, 0, -1, "R8 array continuation 0x101");
    end
    timing_mode = mode; timing_us = US_W'(us);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R11 busy during probe", busy, 1);
      timing_mode = 2'b11; start = 1'b1;
      @(negedge clk);
      start = 1'b0; timing_mode = mode;
    end
    wd = 0;
    while (!done && wd < 100000) begin
      @(negedge clk);
      wd++;
    end
    chk(wd < 100000, "R11 watchdog", wd, 0);
    if (mode == 2'b11) begin
      chk(aborted == 1'b1, "R4 aborted", aborted, 1);
      chk(wd == 0, "R4 done next cycle", wd, 0);
      chk(mfr_id == 16'h0 && dev_id == 16'h0, "R4 ids zero", {mfr_id, dev_id}, 0);
      chk({id_match, parity_err, mfr_alias, dev_alias} == 4'b0, "R4 flags zero",
          {id_match, parity_err, mfr_alias, dev_alias}, 0);
    end else begin
      chk(aborted == 1'b0, "R4 not aborted", aborted, 0);
      chk(mfr_id == em, "R6 mfr_id", mfr_id, em);
      chk(dev_id == ed, "R6 dev_id", dev_id, ed);
      chk(id_match == ((em == exp_mfr) && (ed == exp_dev)), "R10 id_match", id_match,
          (em == exp_mfr) && (ed == exp_dev));
      chk(parity_err == ($countones(em[7:0]) % 2 == 0), "R9 parity_err", parity_err,
          $countones(em[7:0]) % 2 == 0);
      chk(mfr_alias == (em == am), "R8 mfr_alias", mfr_alias, em == am);
      chk(dev_alias == (ed == ad), "R8 dev_alias", dev_alias, ed == ad);
    end
    chk(q_kind.size() == 0, "R11 all operations issued", q_kind.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 done is one cycle", done, 0);
    chk(busy == 1'b0 && q_kind.size() == 0, "R11 idle after done, no extra ops",
        q_kind.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    id0 = 0; id1 = 0; id100 = 0; id101 = 0; ar0 = 0; ar1 = 0; ar100 = 0; ar101 = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_we && !bus_re, "R12 reset idle", {busy, done, bus_we, bus_re}, 0);
    chk(mfr_id == 0 && dev_id == 0 && !id_match && !aborted, "R11 reset outputs",
        {mfr_id, dev_id}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // given time, plain ids, match, second start ignored
    id0 = 8'hBF; id1 = 8'hB6; ar0 = 8'h12; ar1 = 8'h34;
    exp_mfr = 16'h00BF; exp_dev = 16'h00B6;
    probe(2'b00, 3, 1'b1);

    // no wait, manufacturer continuation with even parity, mismatch
    id0 = 8'h7F; id100 = 8'h9C; id1 = 8'h41; ar0 = 8'hFF; ar1 = 8'hFF;
    exp_mfr = 16'h7F9C; exp_dev = 16'h0042;
    probe(2'b01, 0, 1'b0);

    // defaults, device continuation, both identifiers alias the array
    id0 = 8'h20; id1 = 8'h7F; id101 = 8'h12; ar0 = 8'h20; ar1 = 8'h7F; ar101 = 8'h12;
    exp_mfr = 16'h0020; exp_dev = 16'h7F12;
    probe(2'b10, 0, 1'b0);

    // abort setting
    probe(2'b11, 0, 1'b0);

    // given time of zero, both continuations, single level only
    id0 = 8'h7F; id100 = 8'hC2; id1 = 8'h7F; id101 = 8'h7F;
    ar0 = 8'h7F; ar100 = 8'hC2; ar1 = 8'h00; ar101 = 8'h00;
    exp_mfr = 16'h7FC2; exp_dev = 16'h7F7F;
    probe(2'b00, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL R11 global watchdog actual=%0h expected=%0h", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule